// File: doc/BRIEF.md
# Restartable Hold PWM Generator

This block produces the pulse-width-modulated hold signal for a solenoid driver. While hold is enabled, an up-counter runs from zero to a programmable top value and then wraps. The output rises at each wrap and falls when the counter meets a programmable duty compare value. The counter advances on ticks from a power-of-two prescaler, and a small code selects the division ratio. Duty and top values are captured only when a new period begins, so a period that is already running always completes with the settings it started with.

A hold-start request begins a fresh period at once. The output rises on the next cycle, the prescaler restarts from zero, and the duty and top inputs present on the inputs are captured for the new period. A hold-start that arrives while the generator is already running restarts the period in the same way. A hold-stop request drives the output low, freezes the generator and clears the prescaler. Settings changed on the inputs while the generator is idle are simply picked up by the next hold-start.

Top module: `hold_pwm_gen`

## Requirements
- R1: After reset, `hold_out` is low and stays low until a hold-start is seen.
- R2: A cycle with `hold_start` high (and `hold_stop` low) makes `hold_out` high from the next cycle. The same edge clears the prescaler, resets the counter to 0, and captures `duty_in` and `top_in` as the active settings.
- R3: Take code n, ratio R, active duty D and active top T, with D < T. Measured from a hold-start or a wrap, `hold_out` is high for (D+1)·R cycles and low for (T−D)·R cycles, giving a period of (T+1)·R cycles.
- R4: A `div_code` value n from 1 to 15 gives a tick ratio R = 2^(n−1): code 1 divides by 1, code 3 by 4 and code 15 by 16384. Code 0 produces no ticks, so the counter and `hold_out` hold their values.
- R5: A change to `duty_in` or `top_in` while the generator is running takes effect only at the next wrap. The period in progress completes with the old values.
- R6: With active duty 0, `hold_out` is high for exactly one tick period (R cycles) at the start of each period and is low for the rest.
- R7: With active duty greater than or equal to active top, `hold_out` stays high for as long as the generator runs.
- R8: A cycle with `hold_stop` high makes `hold_out` low from the next cycle. It stays low until the next hold-start. If `hold_start` and `hold_stop` are both high in the same cycle, the stop wins.
- R9: Values placed on `duty_in` and `top_in` while the generator is idle are the ones used by the next hold-start.
- R10: A hold-start while the generator is running abandons the current period. A new period then begins from the next cycle with the newly captured settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_start | input | 1 | Begin or restart hold PWM (one-cycle request) |
| hold_stop | input | 1 | End hold PWM, output forced low (one-cycle request) |
| duty_in | input | CNT_W | Duty compare value, captured at start or wrap |
| top_in | input | CNT_W | Counter top (period − 1), captured at start or wrap |
| div_code | input | CODE_W | Prescaler code: 0 stopped, n gives divide by 2^(n−1) |
| hold_out | output | 1 | PWM hold drive |

## Verification
The bench builds the block with its default parameters: an 8-bit counter, a 4-bit divider code and reset settings of 127/255. It drives small top values through the inputs, so many full periods and wraps fit into a short run. Because the code is 4 bits wide, the bench can also use code 15 and watch one complete 16384-cycle tick end the first high phase. It also exercises code 0, the one code that leaves the output frozen.

// File: rtl/hold_pwm_pkg.sv
package hold_pwm_pkg;

  // Division ratio selected by a prescaler code: 0 means stopped.
  function automatic int unsigned div_ratio(input logic [31:0] code);
    if (code == 32'd0) return 0;
    return 32'd1 << (code - 32'd1);
  endfunction

  // The counter has reached its top and wraps on this tick.
  function automatic logic wrap_hit(input logic [31:0] cnt, input logic [31:0] top);
    return cnt == top;
  endfunction

  // The counter meets the duty compare; only meaningful when duty < top.
  function automatic logic clear_hit(input logic [31:0] cnt,
                                     input logic [31:0] duty,
                                     input logic [31:0] top);
    return (cnt == duty) && (duty < top);
  endfunction

endpackage

// File: rtl/hold_pwm_prescaler.sv
module hold_pwm_prescaler
  import hold_pwm_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clr,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int MAX_CODE = (1 << CODE_W) - 1;
  localparam int PRE_W    = (MAX_CODE > 1) ? MAX_CODE - 1 : 1;
  localparam int RW       = PRE_W + 1;

  logic [PRE_W-1:0] pre_q;
  logic [RW-1:0]    ratio_m1;
  logic             code_live;

  always_comb begin
    ratio_m1  = RW'(div_ratio(32'(code)) - 32'd1);
    code_live = (code != '0);
    tick      = run && code_live && !clr && ({1'b0, pre_q} >= ratio_m1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               pre_q <= '0;
    else if (clr || !run || !code_live || tick) pre_q <= '0;
    else                                      pre_q <= pre_q + 1'b1;
  end

endmodule

// File: rtl/hold_pwm_counter.sv
module hold_pwm_counter
  import hold_pwm_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int DEF_DUTY = 127,
  parameter int DEF_TOP  = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             tick,
  input  logic [CNT_W-1:0] duty_in,
  input  logic [CNT_W-1:0] top_in,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] act_duty,
  output logic [CNT_W-1:0] act_top,
  output logic             wrap_ev,
  output logic             match_ev
);
  logic step;

  always_comb begin
    step     = tick && !start && !stop;
    wrap_ev  = step && wrap_hit(32'(cnt_q), 32'(act_top));
    match_ev = step && clear_hit(32'(cnt_q), 32'(act_duty), 32'(act_top));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      act_duty <= CNT_W'(DEF_DUTY);
      act_top  <= CNT_W'(DEF_TOP);
    end else if (stop) begin
      cnt_q <= '0;
    end else if (start || wrap_ev) begin
      cnt_q    <= '0;
      act_duty <= duty_in;
      act_top  <= top_in;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/hold_pwm_driver.sv
module hold_pwm_driver (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  input  logic wrap_ev,
  input  logic match_ev,
  output logic out_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        out_q <= 1'b0;
    else if (stop)     out_q <= 1'b0;
    else if (start)    out_q <= 1'b1;
    else if (wrap_ev)  out_q <= 1'b1;
    else if (match_ev) out_q <= 1'b0;
  end
endmodule

// File: rtl/hold_pwm_gen.sv
module hold_pwm_gen #(
  parameter int CNT_W    = 8,
  parameter int CODE_W   = 4,
  parameter int DEF_DUTY = 127,
  parameter int DEF_TOP  = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_start,
  input  logic              hold_stop,
  input  logic [CNT_W-1:0]  duty_in,
  input  logic [CNT_W-1:0]  top_in,
  input  logic [CODE_W-1:0] div_code,
  output logic              hold_out
);
  logic             run_q;
  logic             tick;
  logic             restart;
  logic             wrap_ev;
  logic             match_ev;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] act_duty;
  logic [CNT_W-1:0] act_top;

  assign restart = hold_start || hold_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_q <= 1'b0;
    else if (hold_stop)  run_q <= 1'b0;
    else if (hold_start) run_q <= 1'b1;
  end

  hold_pwm_prescaler #(.CODE_W(CODE_W)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run_q),
    .clr  (restart),
    .code (div_code),
    .tick (tick)
  );

  hold_pwm_counter #(.CNT_W(CNT_W), .DEF_DUTY(DEF_DUTY), .DEF_TOP(DEF_TOP)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (hold_start),
    .stop    (hold_stop),
    .tick    (tick),
    .duty_in (duty_in),
    .top_in  (top_in),
    .cnt_q   (cnt_q),
    .act_duty(act_duty),
    .act_top (act_top),
    .wrap_ev (wrap_ev),
    .match_ev(match_ev)
  );

  hold_pwm_driver u_drv (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (hold_start),
    .stop    (hold_stop),
    .wrap_ev (wrap_ev),
    .match_ev(match_ev),
    .out_q   (hold_out)
  );

endmodule

// File: rtl/hold_pwm_gen_chk.sv
module hold_pwm_gen_chk #(
  parameter int CNT_W  = 8,
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hold_start,
  input logic              hold_stop,
  input logic [CODE_W-1:0] div_code,
  input logic              hold_out,
  input logic              run_q,
  input logic              tick,
  input logic              wrap_ev,
  input logic              match_ev,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  act_duty,
  input logic [CNT_W-1:0]  act_top
);
  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !hold_out);

  p_start_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_start && !hold_stop) |=> hold_out);

  p_wrap_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev |=> hold_out);

  p_match_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    match_ev |=> !hold_out);

  p_code0_still_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (div_code == '0) |-> !tick);

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q <= act_top));

  p_full_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && (act_duty >= act_top) && !hold_stop) |=> hold_out);

  p_stop_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_stop |=> !hold_out);
endmodule

bind hold_pwm_gen hold_pwm_gen_chk #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hold_start(hold_start),
  .hold_stop (hold_stop),
  .div_code  (div_code),
  .hold_out  (hold_out),
  .run_q     (run_q),
  .tick      (tick),
  .wrap_ev   (wrap_ev),
  .match_ev  (match_ev),
  .cnt_q     (cnt_q),
  .act_duty  (act_duty),
  .act_top   (act_top)
);

// File: tb/hold_pwm_gen_tb.sv
module hold_pwm_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hold_start = 1'b0;
  logic       hold_stop = 1'b0;
  logic [7:0] duty_in = 8'd0;
  logic [7:0] top_in = 8'd0;
  logic [3:0] div_code = 4'd1;
  logic       hold_out;
  int         checks = 0;
  int         fails = 0;

  always #10 clk = ~clk;

  hold_pwm_gen u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_start(hold_start),
    .hold_stop (hold_stop),
    .duty_in   (duty_in),
    .top_in    (top_in),
    .div_code  (div_code),
    .hold_out  (hold_out)
  );

  // Check hold_out for len consecutive negedges; one check per segment.
  task automatic seg(input int len, input logic lvl, input string tag);
    int   bad = -1;
    logic got = 1'b0;
    for (int k = 0; k < len; k++) begin
      if (hold_out !== lvl && bad < 0) begin bad = k; got = hold_out; end
      @(negedge clk);
    end
    checks++;
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s: hold_out=%b expected %b at cycle %0d of %0d", tag, got, lvl, bad, len);
    end
  endtask

  task automatic start_gen(input int d, input int t, input int c);
    duty_in = 8'(d); top_in = 8'(t); div_code = 4'(c);
    hold_start = 1'b1;
    @(negedge clk);
    hold_start = 1'b0;
  endtask

  task automatic stop_gen();
    hold_stop = 1'b1;
    @(negedge clk);
    hold_stop = 1'b0;
    seg(4, 1'b0, "R8 stop");
  endtask

  task automatic t_reset();
    seg(6, 1'b0, "R1 after reset");
  endtask

  task automatic t_basic();
    start_gen(2, 5, 1);
    seg(3, 1'b1, "R2 R3 high D=2");
    seg(3, 1'b0, "R3 low D=2");
    seg(3, 1'b1, "R3 second high");
    seg(3, 1'b0, "R3 second low");
    stop_gen();
  endtask

  task automatic t_prescale();
    start_gen(1, 3, 3);
    seg(8, 1'b1, "R4 code3 high");
    seg(8, 1'b0, "R4 code3 low");
    seg(8, 1'b1, "R4 code3 next high");
    stop_gen();
    start_gen(0, 1, 15);
    seg(16384, 1'b1, "R4 code15 high");
    seg(16384, 1'b0, "R4 code15 low");
    stop_gen();
  endtask

  task automatic t_code0();
    start_gen(0, 3, 0);
    seg(60, 1'b1, "R4 code0 frozen");
    stop_gen();
  endtask

  task automatic t_update_at_wrap();
    start_gen(2, 5, 1);
    seg(3, 1'b1, "R5 old duty high");
    duty_in = 8'd4;
    top_in  = 8'd7;
    seg(3, 1'b0, "R5 old period low");
    seg(5, 1'b1, "R5 new duty high");
    seg(3, 1'b0, "R5 new top low");
    seg(5, 1'b1, "R5 new period high");
    stop_gen();
  endtask

  task automatic t_duty0();
    start_gen(0, 4, 2);
    seg(2, 1'b1, "R6 one tick high");
    seg(8, 1'b0, "R6 low");
    seg(2, 1'b1, "R6 next tick high");
    stop_gen();
  endtask

  task automatic t_full();
    start_gen(9, 5, 1);
    seg(20, 1'b1, "R7 duty above top");
    stop_gen();
    start_gen(5, 5, 1);
    seg(20, 1'b1, "R7 duty equals top");
    stop_gen();
  endtask

  task automatic t_stop();
    start_gen(6, 9, 1);
    seg(3, 1'b1, "R8 before stop");
    hold_stop = 1'b1;
    @(negedge clk);
    hold_stop = 1'b0;
    seg(30, 1'b0, "R8 held low");
    duty_in = 8'd3; top_in = 8'd4;
    hold_start = 1'b1; hold_stop = 1'b1;
    @(negedge clk);
    hold_start = 1'b0; hold_stop = 1'b0;
    seg(20, 1'b0, "R8 stop beats start");
  endtask

  task automatic t_idle_capture();
    duty_in = 8'd3; top_in = 8'd6; div_code = 4'd1;
    seg(10, 1'b0, "R9 idle changes no effect");
    hold_start = 1'b1;
    @(negedge clk);
    hold_start = 1'b0;
    seg(4, 1'b1, "R9 captured duty");
    seg(3, 1'b0, "R9 captured top");
    seg(4, 1'b1, "R9 next period");
    stop_gen();
  endtask

  task automatic t_restart();
    start_gen(5, 9, 1);
    seg(3, 1'b1, "R10 first high");
    start_gen(1, 9, 1);
    seg(2, 1'b1, "R10 restarted high");
    seg(8, 1'b0, "R10 restarted low");
    seg(2, 1'b1, "R10 restarted wrap");
    stop_gen();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_prescale();
    t_code0();
    t_update_at_wrap();
    t_duty0();
    t_full();
    t_stop();
    t_idle_capture();
    t_restart();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule